// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control

This block holds the status and control state of one downstream port of a USB host root hub. It follows the port's line events (attach, detach, low-speed detection, over-current level, end of resume) and keeps a set of live status bits together with sticky change flags. The flags record what hardware did to the port and stay set until software acknowledges them. While any flag is set, the block raises a request to the hub's interrupt logic.

Software reaches the block through a single 32-bit register. A read returns the live status and the change flags. A write carries one-shot commands: enable, disable, suspend, port reset, power on and power off. The same write clears change flags by writing 1 to them. Port reset is a timed sequence counted in millisecond ticks. While it runs, reset signaling is driven to the port. When it ends, the port is enabled and a reset-complete flag is set.

Top module: `rh_port_ctl`

## Requirements
- R1: After synchronous reset, the read value is 0 and port_reset_o, port_enable_o and status_change_o are low.
- R2: A connect event sets the connected bit (read bit 0), loads the low-speed bit (read bit 9) from ev_lowspeed, and sets the connect-change flag (bit 16). A disconnect event clears the connected, enable, suspend and low-speed bits and also sets bit 16.
- R3: The enable-change flag (bit 17) sets only when hardware clears an enable bit that was set in the previous cycle. The hardware causes are a disconnect and a rising over-current. The disable command (write bit 0) clears the enable bit (bit 1) and the suspend bit without setting bit 17.
- R4: The port-reset command (write bit 4) on a connected port sets the reset bit (read bit 4) and port_reset_o. They stay high for exactly 10 ms ticks. On the tenth tick they fall, the enable bit sets and the reset-change flag (bit 20) sets.
- R5: The port-reset command and the enable command (write bit 1) are ignored while the port is not connected.
- R6: The suspend command (write bit 2) sets the suspend bit (read bit 2) only on an enabled port. ev_resume_done on a suspended port clears the suspend bit and sets the suspend-change flag (bit 18).
- R7: The over-current bit (read bit 3) follows oc_level one cycle later. Every change of oc_level sets the over-current-change flag (bit 19). A rising oc_level clears the enable and suspend bits.
- R8: Writing 1 to any of bits 16 to 20 clears that flag. Writing 0 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R9: status_change_o is high exactly while at least one of bits 16 to 20 is set.
- R10: The power-on command (write bit 8) sets the power bit (read bit 8), and the power-off command (write bit 9) clears it.
- R11: A disconnect during port reset ends the reset at once, without setting bit 20 and without enabling the port. This holds even when the disconnect falls on the tick that would have completed the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: command bits and flag clears |
| rd_data | output | 32 | Live status and change flags |
| ev_connect | input | 1 | One-cycle device attach event |
| ev_disconnect | input | 1 | One-cycle device detach event |
| ev_lowspeed | input | 1 | Low-speed device indication, sampled with ev_connect |
| oc_level | input | 1 | Over-current level from the port |
| ev_resume_done | input | 1 | One-cycle end of the resume sequence |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| port_reset_o | output | 1 | Reset signaling to the port |
| port_enable_o | output | 1 | Port enabled |
| status_change_o | output | 1 | Status-change request to the interrupt logic |

## Verification
Two collisions carry the most risk. In the first, a hardware event sets a change flag in the same cycle that software writes 1 to clear it. The bench drives a connect event together with a clear of bit 16, and expects the flag to remain set. In the second, the tick that ends a port reset coincides with a disconnect. The bench expects the port to end up disconnected, not enabled, and without a reset-change flag. A behavioural model in the bench predicts the whole register on every clock, so both collisions are judged against the model as well as by explicit checks.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_CHG   = 5;
    localparam int CHG_BASE  = 16;

    // read-side bit positions (decoded by the hub driver)
    localparam int RB_CONN = 0;
    localparam int RB_EN   = 1;
    localparam int RB_SUSP = 2;
    localparam int RB_OC   = 3;
    localparam int RB_RST  = 4;
    localparam int RB_PWR  = 8;
    localparam int RB_LS   = 9;

    // write-side command bit positions
    localparam int WB_CLR_EN   = 0;
    localparam int WB_SET_EN   = 1;
    localparam int WB_SET_SUSP = 2;
    localparam int WB_START_RS = 4;
    localparam int WB_PWR_ON   = 8;
    localparam int WB_PWR_OFF  = 9;

    typedef enum logic [2:0] {
        CHG_CONN = 3'd0,
        CHG_EN   = 3'd1,
        CHG_SUSP = 3'd2,
        CHG_OC   = 3'd3,
        CHG_RST  = 3'd4
    } chg_idx_e;

    typedef struct packed {
        logic ls;
        logic pwr;
        logic oc;
        logic susp;
        logic en;
        logic conn;
    } port_core_t;

    typedef struct packed {
        logic               clr_en;
        logic               set_en;
        logic               set_susp;
        logic               start_rst;
        logic               pwr_on;
        logic               pwr_off;
        logic [NUM_CHG-1:0] chg_clr;
    } port_cmd_t;

    function automatic logic [REG_W-1:0] pack_status(
        input port_core_t         c,
        input logic               rst_active,
        input logic [NUM_CHG-1:0] chg
    );
        logic [REG_W-1:0] v;
        v          = '0;
        v[RB_CONN] = c.conn;
        v[RB_EN]   = c.en;
        v[RB_SUSP] = c.susp;
        v[RB_OC]   = c.oc;
        v[RB_RST]  = rst_active;
        v[RB_PWR]  = c.pwr;
        v[RB_LS]   = c.ls;
        v[CHG_BASE +: NUM_CHG] = chg;
        return v;
    endfunction

endpackage

// File: rtl/rh_cmd_decode.sv
module rh_cmd_decode
    import rh_port_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output port_cmd_t        cmd
);
    always_comb begin
        cmd           = '0;
        if (wr_en) begin
            cmd.clr_en    = wr_data[WB_CLR_EN];
            cmd.set_en    = wr_data[WB_SET_EN];
            cmd.set_susp  = wr_data[WB_SET_SUSP];
            cmd.start_rst = wr_data[WB_START_RS];
            cmd.pwr_on    = wr_data[WB_PWR_ON];
            cmd.pwr_off   = wr_data[WB_PWR_OFF];
            cmd.chg_clr   = wr_data[CHG_BASE +: NUM_CHG];
        end
    end
endmodule

// File: rtl/rh_reset_timer.sv
module rh_reset_timer #(
    parameter int RESET_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic ms_tick,
    output logic active,
    output logic done
);
    localparam int CNT_W = $clog2(RESET_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RESET_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = active && ms_tick && (cnt_q == LAST) && !abort;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (active) begin
            if (ms_tick) begin
                if (cnt_q == LAST) begin
                    active <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end else if (start) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end
    end
endmodule

// File: rtl/rh_change_flags.sv
module rh_change_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags,
    output logic         any
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    flags[i] <= 1'b0;
                else if (set[i])
                    flags[i] <= 1'b1;
                else if (clr[i])
                    flags[i] <= 1'b0;
            end
        end
    endgenerate

    assign any = |flags;
endmodule

// File: rtl/rh_port_ctl.sv
module rh_port_ctl
    import rh_port_pkg::*;
#(
    parameter int RESET_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_connect,
    input  logic             ev_disconnect,
    input  logic             ev_lowspeed,
    input  logic             oc_level,
    input  logic             ev_resume_done,
    input  logic             ms_tick,
    output logic             port_reset_o,
    output logic             port_enable_o,
    output logic             status_change_o
);
    port_cmd_t          cmd;
    port_core_t         core_q, core_d;
    logic [NUM_CHG-1:0] chg_set, chg_q;
    logic               rs_active, rs_done, rs_start;

    rh_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    assign rs_start = cmd.start_rst && core_q.conn && !rs_active;

    rh_reset_timer #(.RESET_TICKS(RESET_TICKS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (rs_start),
        .abort   (ev_disconnect),
        .ms_tick (ms_tick),
        .active  (rs_active),
        .done    (rs_done)
    );

    always_comb begin
        core_d  = core_q;
        chg_set = '0;

        // software commands
        if (cmd.clr_en) begin
            core_d.en   = 1'b0;
            core_d.susp = 1'b0;
        end
        if (cmd.set_en && core_q.conn)
            core_d.en = 1'b1;
        if (cmd.set_susp && core_q.en)
            core_d.susp = 1'b1;
        if (cmd.pwr_on)
            core_d.pwr = 1'b1;
        if (cmd.pwr_off)
            core_d.pwr = 1'b0;

        // end of timed port reset
        if (rs_done) begin
            core_d.en        = 1'b1;
            chg_set[CHG_RST] = 1'b1;
        end

        // resume finished
        if (ev_resume_done && core_q.susp) begin
            core_d.susp       = 1'b0;
            chg_set[CHG_SUSP] = 1'b1;
        end

        // over-current level tracking
        core_d.oc = oc_level;
        if (oc_level != core_q.oc)
            chg_set[CHG_OC] = 1'b1;
        if (oc_level && !core_q.oc) begin
            if (core_q.en)
                chg_set[CHG_EN] = 1'b1;
            core_d.en   = 1'b0;
            core_d.susp = 1'b0;
        end

        // attach
        if (ev_connect) begin
            core_d.conn       = 1'b1;
            core_d.ls         = ev_lowspeed;
            chg_set[CHG_CONN] = 1'b1;
        end

        // detach has the last word
        if (ev_disconnect) begin
            if (core_q.en)
                chg_set[CHG_EN] = 1'b1;
            core_d.conn       = 1'b0;
            core_d.en         = 1'b0;
            core_d.susp       = 1'b0;
            core_d.ls         = 1'b0;
            chg_set[CHG_CONN] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            core_q <= '0;
        else
            core_q <= core_d;
    end

    rh_change_flags #(.N(NUM_CHG)) u_chg (
        .clk   (clk),
        .rst   (rst),
        .set   (chg_set),
        .clr   (cmd.chg_clr),
        .flags (chg_q),
        .any   (status_change_o)
    );

    assign rd_data       = pack_status(core_q, rs_active, chg_q);
    assign port_reset_o  = rs_active;
    assign port_enable_o = core_q.en;

endmodule

// File: rtl/rh_port_ctl_chk.sv
module rh_port_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] rd_data,
    input logic        port_reset_o,
    input logic        port_enable_o,
    input logic        status_change_o
);
    // R2
    conn_rise_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[0]) |-> rd_data[16]);

    // R3
    en_chg_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[17]) |-> ($past(rd_data[1]) && !rd_data[1] && !port_enable_o));

    // R4
    reset_end_enables_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(port_reset_o) && rd_data[0] && !$rose(rd_data[3]))
            |-> (rd_data[1] && rd_data[20]));

    // R5
    no_reset_detached_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[0] |-> !port_reset_o);

    // R6
    resume_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_data[2]) && rd_data[1]) |-> rd_data[18]);

    // R7
    oc_change_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3] != $past(rd_data[3])) |-> rd_data[19]);

    // R9
    request_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[20]) |-> status_change_o);

    // R11
    abort_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(port_reset_o) && !rd_data[0]) |-> !$rose(rd_data[20]));
endmodule

bind rh_port_ctl rh_port_ctl_chk u_chk (.*);

// File: tb/rh_port_ctl_test.sv
module rh_port_ctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ev_connect = 1'b0, ev_disconnect = 1'b0, ev_lowspeed = 1'b0;
    logic        oc_level = 1'b0, ev_resume_done = 1'b0, ms_tick = 1'b0;
    logic        port_reset_o, port_enable_o, status_change_o;

    always #5 clk = ~clk;

    rh_port_ctl uut (.*);

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural reference state
    bit       m_conn, m_en, m_susp, m_oc, m_pwr, m_ls, m_rst;
    int       m_ticks;
    bit [4:0] m_chg;

    function automatic logic [31:0] model_rd();
        logic [31:0] v = '0;
        v[0] = m_conn; v[1] = m_en; v[2] = m_susp; v[3] = m_oc;
        v[4] = m_rst;  v[8] = m_pwr; v[9] = m_ls;
        v[20:16] = m_chg;
        return v;
    endfunction

    always @(posedge clk) begin
        bit       o_conn, o_en, o_susp, o_oc, o_rst;
        bit [4:0] setm, clrm;
        if (rst) begin
            {m_conn, m_en, m_susp, m_oc, m_pwr, m_ls, m_rst} = '0;
            m_ticks = 0;
            m_chg   = '0;
        end else begin
            o_conn = m_conn; o_en = m_en; o_susp = m_susp; o_oc = m_oc; o_rst = m_rst;
            setm = '0;
            clrm = wr_en ? wr_data[20:16] : 5'b0;
            if (wr_en) begin
                if (wr_data[0]) begin m_en = 0; m_susp = 0; end
                if (wr_data[1] && o_conn) m_en = 1;
                if (wr_data[2] && o_en) m_susp = 1;
                if (wr_data[8]) m_pwr = 1;
                if (wr_data[9]) m_pwr = 0;
            end
            if (ev_disconnect) begin
                m_rst = 0; m_ticks = 0;
            end else if (o_rst) begin
                if (ms_tick) begin
                    m_ticks++;
                    if (m_ticks == 10) begin
                        m_rst = 0; m_ticks = 0; m_en = 1; setm[4] = 1;
                    end
                end
            end else if (wr_en && wr_data[4] && o_conn) begin
                m_rst = 1; m_ticks = 0;
            end
            if (ev_resume_done && o_susp) begin m_susp = 0; setm[2] = 1; end
            m_oc = oc_level;
            if (oc_level != o_oc) setm[3] = 1;
            if (oc_level && !o_oc) begin
                if (o_en) setm[1] = 1;
                m_en = 0; m_susp = 0;
            end
            if (ev_connect) begin m_conn = 1; m_ls = ev_lowspeed; setm[0] = 1; end
            if (ev_disconnect) begin
                if (o_en) setm[1] = 1;
                m_conn = 0; m_en = 0; m_susp = 0; m_ls = 0; setm[0] = 1;
            end
            m_chg = (m_chg & ~clrm) | setm;
        end
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // per-cycle comparison against the model, plus watchdog
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            n_cmp++;
            if (rd_data !== model_rd() || port_reset_o !== m_rst ||
                port_enable_o !== m_en || status_change_o !== (|m_chg)) begin
                n_bad++;
                $display("FAIL %s cycle %0d: rd=%h rst=%b en=%b irq=%b expected rd=%h rst=%b en=%b irq=%b",
                         cur_req, cyc, rd_data, port_reset_o, port_enable_o, status_change_o,
                         model_rd(), m_rst, m_en, |m_chg);
            end
        end
        if (cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got cycle %0d expected < 150000", cyc);
            summary_and_end();
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic connect(input logic ls);
        @(negedge clk); ev_connect = 1'b1; ev_lowspeed = ls;
        @(negedge clk); ev_connect = 1'b0; ev_lowspeed = 1'b0;
    endtask

    task automatic disconnect();
        @(negedge clk); ev_disconnect = 1'b1;
        @(negedge clk); ev_disconnect = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        check("R1 rd", rd_data, 32'h0);
        check("R1 outs", {29'b0, port_reset_o, port_enable_o, status_change_o}, 32'h0);

        // R5: reset and enable commands ignored while detached
        cur_req = "R5";
        wr(32'h0000_0012);
        idle(1);
        check("R5 ignored", rd_data, 32'h0);
        check("R5 no reset", {31'b0, port_reset_o}, 32'h0);

        // R2: low-speed attach
        cur_req = "R2";
        connect(1'b1);
        check("R2 attach", rd_data, 32'h0001_0201);
        // R9: request raised
        check("R9 request", {31'b0, status_change_o}, 32'h1);

        // R8: write 0 keeps, write 1 clears
        cur_req = "R8";
        wr(32'h0000_0000);
        check("R8 zero keeps", rd_data[16], 1'b1);
        wr(32'h0001_0000);
        check("R8 w1c", rd_data, 32'h0000_0201);
        check("R9 request low", {31'b0, status_change_o}, 32'h0);

        // R4: timed port reset
        cur_req = "R4";
        wr(32'h0000_0010);
        check("R4 reset on", {31'b0, port_reset_o}, 32'h1);
        for (int i = 0; i < 9; i++) tick();
        check("R4 after 9 ticks", rd_data, 32'h0000_0211);
        tick();
        check("R4 after 10 ticks", rd_data, 32'h0010_0203);
        wr(32'h0010_0000);

        // R6: suspend and resume
        cur_req = "R6";
        wr(32'h0000_0004);
        check("R6 suspended", rd_data[2], 1'b1);
        @(negedge clk); ev_resume_done = 1'b1;
        @(negedge clk); ev_resume_done = 1'b0;
        check("R6 resumed", rd_data, 32'h0004_0203);
        wr(32'h0004_0000);

        // R3: software disable gives no enable-change flag
        cur_req = "R3";
        wr(32'h0000_0001);
        check("R3 sw disable", rd_data, 32'h0000_0201);
        wr(32'h0000_0002);
        check("R3 re-enable", rd_data[1], 1'b1);

        // R7: over-current rise clears enable, both edges flag
        cur_req = "R7";
        @(negedge clk); oc_level = 1'b1;
        idle(1);
        check("R7 oc rise", rd_data, 32'h000A_0209);
        wr(32'h000A_0000);
        @(negedge clk); oc_level = 1'b0;
        idle(1);
        check("R7 oc fall", rd_data, 32'h0008_0201);
        wr(32'h0008_0000);

        // R10: power control
        cur_req = "R10";
        wr(32'h0000_0100);
        check("R10 power on", rd_data[8], 1'b1);
        wr(32'h0000_0200);
        check("R10 power off", rd_data[8], 1'b0);

        // R8: hardware set wins over same-cycle clear
        cur_req = "R8";
        @(negedge clk); ev_connect = 1'b1; ev_lowspeed = 1'b0;
        wr_en = 1'b1; wr_data = 32'h0001_0000;
        @(negedge clk); ev_connect = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R8 set beats clear", rd_data, 32'h0001_0001);
        wr(32'h0001_0000);

        // R11: disconnect mid-reset aborts without reset flag
        cur_req = "R11";
        wr(32'h0000_0010);
        tick(); tick();
        disconnect();
        check("R11 abort", rd_data, 32'h0001_0000);
        wr(32'h0001_0000);

        // R11: disconnect on the completing tick
        connect(1'b0);
        wr(32'h0001_0010);
        for (int i = 0; i < 9; i++) tick();
        @(negedge clk); ms_tick = 1'b1; ev_disconnect = 1'b1;
        @(negedge clk); ms_tick = 1'b0; ev_disconnect = 1'b0;
        check("R11 collide", rd_data, 32'h0001_0000);
        check("R11 not enabled", {31'b0, port_enable_o}, 32'h0);

        // R3: disconnect of an enabled port flags enable change
        cur_req = "R3";
        wr(32'h0001_0000);
        connect(1'b0);
        wr(32'h0001_0002);
        disconnect();
        check("R3 hw disable", rd_data, 32'h0003_0000);

        idle(3);
        finished = 1'b1;
        summary_and_end();
    end
endmodule